// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block holds a small set of recent virtual-to-physical page translations and answers address lookups against all of them at once. Every slot stores a virtual tag taken from the upper bits of a 24-bit address, a 2-bit page-size kind, a valid bit and a "keep" flag. Its data half holds a physical tag, the upper 22 bits of a 32-bit address, and a 2-bit access permission. During a lookup each slot compares only the tag bits that lie above the offset of its own page size. The physical address is then built from the stored physical tag above that offset and from the request address below it.

New translations come from a table walker through a fill strobe. A fill lands in a pseudo-random slot whose index is at least the lock base, so slots below the base stay pinned. Software can also place or inspect a translation by hand. It first loads a slot pointer and then writes or reads the slot that pointer addresses. A global flush drops every slot whose keep flag is clear. A tag flush drops the slot that matches a supplied tag, whatever its keep flag. Both flush inputs are single-cycle strobes, so they clear themselves.

Lookups use a valid/ready request stream and a valid/ready response stream. The response is registered one cycle after acceptance. A request is accepted only while `req_ready` is high, and `req_ready` is high whenever the response register is empty or is being drained in the same cycle. While `rsp_ready` is low, the response is held unchanged. The slot count must be a power of two.

Top module: `tlb_lockable`

## Requirements
- R1: A slot of kind 00 (1 MB page) hits when its tag matches request bits 23:20. The response then has `rsp_hit`=1, `rsp_paddr` = {stored physical bits 31:20, request bits 19:0}, and `rsp_ap` = the stored permission.
- R2: Kinds 01 (64 KB), 10 (4 KB) and 11 (1 KB) compare request bits 23:16, 23:12 and 23:10. Their physical addresses use stored physical bits 31:16, 31:12 and 31:10, with the request address supplying the bits below. A request outside the page misses.
- R3: After reset, and on any lookup that matches no valid slot, the response has `rsp_hit`=0, `rsp_paddr`=0 and `rsp_ap`=0.
- R4: An accepted request is answered on the next cycle with `rsp_valid`=1. While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and the response holds every value.
- R5: A fill writes a slot whose index is at least `lock_base`. Slots 0 to `lock_base`-1 keep their contents across any number of fills.
- R6: `ptr_load` sets the slot pointer to `ptr_value`. `ent_wr` writes a valid entry, including the given keep flag, into the slot the pointer addresses. When both are strobed, `ent_wr` takes priority over `fill_en`.
- R7: `ent_rd` presents the fields of the slot at the pointer on the `rd_*` outputs one cycle later.
- R8: `flush_all` invalidates every slot whose keep flag is 0 and leaves slots whose keep flag is 1 valid.
- R9: `flush_one` invalidates the valid slot whose tag matches `flush_vtag` (compared at that slot's page size), even when its keep flag is 1.
- R10: The keep flag does not protect a slot from being overwritten by a fill. A fill always writes its entry with the keep flag 0.
- R11: A lookup accepted in the same cycle as a flush sees the result of the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_vaddr | input | 24 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_ap | output | 2 | Access permission of the hit slot |
| lock_base | input | 5 | Slots below this index are pinned |
| ptr_load | input | 1 | Load the slot pointer |
| ptr_value | input | 5 | New slot pointer value |
| ent_wr | input | 1 | Manual write at the slot pointer |
| fill_en | input | 1 | Walker fill into a random unlocked slot |
| ent_vtag | input | 14 | Virtual tag (address bits 23:10) for write or fill |
| ent_kind | input | 2 | Page kind for write or fill |
| ent_ptag | input | 22 | Physical tag (address bits 31:10) for write or fill |
| ent_ap | input | 2 | Access permission for write or fill |
| ent_pres | input | 1 | Keep flag for a manual write |
| ent_rd | input | 1 | Manual read at the slot pointer |
| rd_valid | output | 1 | Read-back valid bit |
| rd_vtag | output | 14 | Read-back virtual tag |
| rd_kind | output | 2 | Read-back page kind |
| rd_ptag | output | 22 | Read-back physical tag |
| rd_ap | output | 2 | Read-back permission |
| rd_pres | output | 1 | Read-back keep flag |
| flush_all | input | 1 | Global flush strobe |
| flush_one | input | 1 | Tag flush strobe |
| flush_vtag | input | 14 | Tag to flush |

## Verification
The checks assume that no two valid slots ever translate the same address, because the output multiplexer merges hits without priority. The stimulus keeps every tag it writes or fills distinct, and it keeps those tags apart in every page size it uses. They also assume that `ent_wr` and `fill_en` are not strobed together, except where the bench tests their priority. The lock base stays constant while fills run, so every fill falls inside the range that the base allows.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    PG_SEC   = 2'b00,
    PG_LARGE = 2'b01,
    PG_SMALL = 2'b10,
    PG_TINY  = 2'b11
  } pg_kind_e;

  // number of offset bits kept from the request address for each page kind
  function automatic int pg_shift(pg_kind_e k);
    case (k)
      PG_SEC:   pg_shift = 20;
      PG_LARGE: pg_shift = 16;
      PG_SMALL: pg_shift = 12;
      default:  pg_shift = 10;
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
#(
  parameter int VT_W   = 14,
  parameter int PT_W   = 22,
  parameter int MIN_PG = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [VT_W-1:0] ld_vtag,
  input  pg_kind_e        ld_kind,
  input  logic [PT_W-1:0] ld_ptag,
  input  logic [1:0]      ld_ap,
  input  logic            ld_pres,
  input  logic            flush_all,
  input  logic            flush_one,
  input  logic [VT_W-1:0] flush_vtag,
  input  logic [VT_W-1:0] lk_vtag,
  output logic            hit,
  output logic            valid_o,
  output logic [VT_W-1:0] vtag_o,
  output pg_kind_e        kind_o,
  output logic [PT_W-1:0] ptag_o,
  output logic [1:0]      ap_o,
  output logic            pres_o
);
  logic [VT_W-1:0] cmp_mask;
  logic            kill, live;

  always_comb begin
    for (int i = 0; i < VT_W; i++)
      cmp_mask[i] = ((i + MIN_PG) >= pg_shift(kind_o));
  end

  assign kill = (flush_all && !pres_o) ||
                (flush_one && (((flush_vtag ^ vtag_o) & cmp_mask) == '0));
  assign live = valid_o && !kill;
  assign hit  = live && (((lk_vtag ^ vtag_o) & cmp_mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      vtag_o  <= '0;
      kind_o  <= PG_SEC;
      ptag_o  <= '0;
      ap_o    <= '0;
      pres_o  <= 1'b0;
    end else if (load) begin
      valid_o <= 1'b1;
      vtag_o  <= ld_vtag;
      kind_o  <= ld_kind;
      ptag_o  <= ld_ptag;
      ap_o    <= ld_ap;
      pres_o  <= ld_pres;
    end else begin
      valid_o <= live;
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  parameter int LFSR_W  = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lock_base,
  output logic [IDX_W-1:0] victim
);
  logic [LFSR_W-1:0]  lfsr;
  logic [IDX_W:0]     span;
  logic [2*IDX_W:0]   prod;
  logic [IDX_W:0]     sum;

  // maximal-length Fibonacci taps 16,14,13,11
  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= {{(LFSR_W-1){1'b0}}, 1'b1};
    else        lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // scale a random index into [lock_base, ENTRIES-1]
  assign span   = (IDX_W+1)'(ENTRIES) - {1'b0, lock_base};
  assign prod   = (2*IDX_W+1)'(lfsr[IDX_W-1:0]) * (2*IDX_W+1)'(span);
  assign sum    = {1'b0, lock_base} + prod[2*IDX_W:IDX_W];
  assign victim = sum[IDX_W-1:0];
endmodule

// File: rtl/tlb_lockable.sv
module tlb_lockable
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 24,
  parameter int PA_W    = 32,
  parameter int MIN_PG  = 10,
  parameter int LFSR_W  = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VT_W   = VA_W - MIN_PG,
  localparam int PT_W   = PA_W - MIN_PG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_ap,
  input  logic [IDX_W-1:0] lock_base,
  input  logic             ptr_load,
  input  logic [IDX_W-1:0] ptr_value,
  input  logic             ent_wr,
  input  logic             fill_en,
  input  logic [VT_W-1:0]  ent_vtag,
  input  logic [1:0]       ent_kind,
  input  logic [PT_W-1:0]  ent_ptag,
  input  logic [1:0]       ent_ap,
  input  logic             ent_pres,
  input  logic             ent_rd,
  output logic             rd_valid,
  output logic [VT_W-1:0]  rd_vtag,
  output logic [1:0]       rd_kind,
  output logic [PT_W-1:0]  rd_ptag,
  output logic [1:0]       rd_ap,
  output logic             rd_pres,
  input  logic             flush_all,
  input  logic             flush_one,
  input  logic [VT_W-1:0]  flush_vtag
);
  logic [IDX_W-1:0] vptr, victim;
  logic [ENTRIES-1:0] hit_vec, valid_vec, pres_vec, load_vec;
  logic [VT_W-1:0]  s_vtag [ENTRIES];
  pg_kind_e         s_kind [ENTRIES];
  logic [PT_W-1:0]  s_ptag [ENTRIES];
  logic [1:0]       s_ap   [ENTRIES];
  logic [VT_W-1:0]  lk_vtag;
  logic             ld_pres;

  assign lk_vtag = req_vaddr[VA_W-1:MIN_PG];
  assign ld_pres = ent_wr ? ent_pres : 1'b0;

  tlb_victim #(.ENTRIES(ENTRIES), .LFSR_W(LFSR_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .lock_base(lock_base), .victim(victim)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign load_vec[g] = ent_wr ? (vptr == IDX_W'(g)) : (fill_en && victim == IDX_W'(g));
    tlb_entry #(.VT_W(VT_W), .PT_W(PT_W), .MIN_PG(MIN_PG)) u_entry (
      .clk(clk), .rst_n(rst_n), .load(load_vec[g]),
      .ld_vtag(ent_vtag), .ld_kind(pg_kind_e'(ent_kind)), .ld_ptag(ent_ptag),
      .ld_ap(ent_ap), .ld_pres(ld_pres),
      .flush_all(flush_all), .flush_one(flush_one), .flush_vtag(flush_vtag),
      .lk_vtag(lk_vtag), .hit(hit_vec[g]), .valid_o(valid_vec[g]),
      .vtag_o(s_vtag[g]), .kind_o(s_kind[g]), .ptag_o(s_ptag[g]),
      .ap_o(s_ap[g]), .pres_o(pres_vec[g])
    );
  end

  // one-hot merge of the matching slot
  logic [PT_W-1:0] m_ptag;
  logic [1:0]      m_kind, m_ap;
  logic [PA_W-1:0] m_pa, full_pt, va_ext;
  always_comb begin
    m_ptag = '0;
    m_kind = '0;
    m_ap   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        m_ptag |= s_ptag[i];
        m_kind |= s_kind[i];
        m_ap   |= s_ap[i];
      end
    end
    full_pt = {m_ptag, {MIN_PG{1'b0}}};
    va_ext  = PA_W'(req_vaddr);
    for (int b = 0; b < PA_W; b++)
      m_pa[b] = (b < pg_shift(pg_kind_e'(m_kind))) ? va_ext[b] : full_pt[b];
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_ap    <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= |hit_vec;
      rsp_paddr <= (|hit_vec) ? m_pa : '0;
      rsp_ap    <= (|hit_vec) ? m_ap : 2'b00;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vptr <= '0;
    else if (ptr_load) vptr <= ptr_value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_vtag  <= '0;
      rd_kind  <= '0;
      rd_ptag  <= '0;
      rd_ap    <= '0;
      rd_pres  <= 1'b0;
    end else if (ent_rd) begin
      rd_valid <= valid_vec[vptr];
      rd_vtag  <= s_vtag[vptr];
      rd_kind  <= s_kind[vptr];
      rd_ptag  <= s_ptag[vptr];
      rd_ap    <= s_ap[vptr];
      rd_pres  <= pres_vec[vptr];
    end
  end
endmodule

// File: rtl/tlb_lockable_chk.sv
module tlb_lockable_chk #(
  parameter int ENTRIES = 32,
  parameter int PA_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_hit,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic [1:0]         rsp_ap,
  input logic               fill_en,
  input logic               ent_wr,
  input logic               flush_all,
  input logic [IDX_W-1:0]   lock_base,
  input logic [IDX_W-1:0]   victim,
  input logic [ENTRIES-1:0] load_vec,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] pres_vec
);
  AST_VICTIM_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !ent_wr) |-> (victim >= lock_base)); // R5
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec)); // R6
  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_ap == 2'b00)); // R3
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit) && $stable(rsp_ap))); // R4
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R4
  AST_GFLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !ent_wr && !fill_en) |=> ((valid_vec & ~pres_vec) == '0)); // R8
endmodule

bind tlb_lockable tlb_lockable_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_ap(rsp_ap),
  .fill_en(fill_en), .ent_wr(ent_wr), .flush_all(flush_all), .lock_base(lock_base),
  .victim(victim), .load_vec(load_vec), .hit_vec(hit_vec), .valid_vec(valid_vec),
  .pres_vec(pres_vec)
);

// File: tb/tlb_lockable_test.sv
module tlb_lockable_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, req_valid, req_ready, rsp_valid, rsp_ready, rsp_hit;
  logic [23:0] req_vaddr;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_ap;
  logic [4:0]  lock_base, ptr_value;
  logic        ptr_load, ent_wr, fill_en, ent_pres, ent_rd;
  logic [13:0] ent_vtag, flush_vtag, rd_vtag;
  logic [1:0]  ent_kind, ent_ap, rd_kind, rd_ap;
  logic [21:0] ent_ptag, rd_ptag;
  logic        rd_valid, rd_pres, flush_all, flush_one;

  int checks = 0;
  int fails  = 0;

  tlb_lockable uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_ap(rsp_ap),
    .lock_base(lock_base), .ptr_load(ptr_load), .ptr_value(ptr_value),
    .ent_wr(ent_wr), .fill_en(fill_en), .ent_vtag(ent_vtag), .ent_kind(ent_kind),
    .ent_ptag(ent_ptag), .ent_ap(ent_ap), .ent_pres(ent_pres), .ent_rd(ent_rd),
    .rd_valid(rd_valid), .rd_vtag(rd_vtag), .rd_kind(rd_kind), .rd_ptag(rd_ptag),
    .rd_ap(rd_ap), .rd_pres(rd_pres), .flush_all(flush_all), .flush_one(flush_one),
    .flush_vtag(flush_vtag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected physical address per requirement R1/R2
  function automatic logic [31:0] exp_pa(input logic [1:0] kind, input logic [21:0] pt,
                                         input logic [23:0] va);
    int sh;
    logic [31:0] m;
    sh = (kind == 2'b00) ? 20 : (kind == 2'b01) ? 16 : (kind == 2'b10) ? 12 : 10;
    m  = (32'h1 << sh) - 32'h1;
    return ({pt, 10'b0} & ~m) | ({8'h0, va} & m);
  endfunction

  task automatic idle();
    req_valid = 0; rsp_ready = 1; req_vaddr = '0; lock_base = '0;
    ptr_load = 0; ptr_value = '0; ent_wr = 0; fill_en = 0; ent_vtag = '0;
    ent_kind = '0; ent_ptag = '0; ent_ap = '0; ent_pres = 0; ent_rd = 0;
    flush_all = 0; flush_one = 0; flush_vtag = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic set_ptr(input int idx);
    @(negedge clk); ptr_load = 1; ptr_value = 5'(idx);
    @(negedge clk); ptr_load = 0;
  endtask

  task automatic put(input int idx, input logic [13:0] vt, input logic [1:0] k,
                     input logic [21:0] pt, input logic [1:0] ap, input logic pres);
    set_ptr(idx);
    ent_wr = 1; ent_vtag = vt; ent_kind = k; ent_ptag = pt; ent_ap = ap; ent_pres = pres;
    @(negedge clk); ent_wr = 0;
  endtask

  task automatic look(input string req, input logic [23:0] va, input logic hit,
                      input logic [31:0] pa, input logic [1:0] ap);
    @(negedge clk); req_valid = 1; req_vaddr = va; rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    chk({req, " rsp_valid"}, 64'(rsp_valid), 64'(1'b1));
    chk({req, " hit"}, 64'(rsp_hit), 64'(hit));
    chk({req, " paddr"}, 64'(rsp_paddr), 64'(hit ? pa : 32'h0));
    chk({req, " ap"}, 64'(rsp_ap), 64'(hit ? ap : 2'b00));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R3 reset rsp_valid", 64'(rsp_valid), 0);
    chk("R4 reset req_ready", 64'(req_ready), 1);
    look("R3 empty", 24'h123456, 0, 0, 0);
  endtask

  task automatic t_sizes();
    do_reset();
    put(3, 14'h1400, 2'b00, 22'h2A5C00, 2'b11, 0);   // section va 5xxxxx
    look("R1 section", 24'h5ABCDE, 1, exp_pa(2'b00, 22'h2A5C00, 24'h5ABCDE), 2'b11);
    look("R1 section miss", 24'h6ABCDE, 0, 0, 0);
    put(7, 14'h0AC0, 2'b01, 22'h111140, 2'b10, 0);   // large va 2Bxxxx
    look("R2 large", 24'h2B1234, 1, exp_pa(2'b01, 22'h111140, 24'h2B1234), 2'b10);
    look("R2 large miss", 24'h2C1234, 0, 0, 0);
    put(9, 14'h0C4C, 2'b10, 22'h0F0F0C, 2'b01, 0);   // small va 313xxx
    look("R2 small", 24'h313ABC, 1, exp_pa(2'b10, 22'h0F0F0C, 24'h313ABC), 2'b01);
    look("R2 small miss", 24'h314ABC, 0, 0, 0);
    put(12, 14'h0E05, 2'b11, 22'h3FFFFF, 2'b11, 0);  // tiny va 381400..3817FF
    look("R2 tiny", 24'h3815F0, 1, exp_pa(2'b11, 22'h3FFFFF, 24'h3815F0), 2'b11);
    look("R2 tiny miss", 24'h381800, 0, 0, 0);
  endtask

  task automatic t_handshake();
    do_reset();
    put(0, 14'h1400, 2'b00, 22'h000400, 2'b11, 0);
    @(negedge clk); req_valid = 1; req_vaddr = 24'h512345; rsp_ready = 0;
    @(negedge clk); req_vaddr = 24'h600000;
    chk("R4 stall valid", 64'(rsp_valid), 1);
    chk("R4 stall ready low", 64'(req_ready), 0);
    chk("R4 stall paddr", 64'(rsp_paddr), 64'(exp_pa(2'b00, 22'h000400, 24'h512345)));
    @(negedge clk);
    chk("R4 hold paddr", 64'(rsp_paddr), 64'(exp_pa(2'b00, 22'h000400, 24'h512345)));
    chk("R4 hold hit", 64'(rsp_hit), 1);
    rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    chk("R4 next hit", 64'(rsp_hit), 0);
    chk("R4 next valid", 64'(rsp_valid), 1);
    @(negedge clk);
    chk("R4 drained", 64'(rsp_valid), 0);
  endtask

  task automatic t_readback();
    do_reset();
    put(21, 14'h2A1F, 2'b11, 22'h155AA5, 2'b10, 1);
    set_ptr(21);
    ent_rd = 1;
    @(negedge clk); ent_rd = 0;
    chk("R7 rd_valid", 64'(rd_valid), 1);
    chk("R7 rd_vtag", 64'(rd_vtag), 64'(14'h2A1F));
    chk("R7 rd_kind", 64'(rd_kind), 3);
    chk("R7 rd_ptag", 64'(rd_ptag), 64'(22'h155AA5));
    chk("R7 rd_ap", 64'(rd_ap), 2);
    chk("R6 rd_pres", 64'(rd_pres), 1);
    // R6 write beats a fill strobed in the same cycle
    set_ptr(22);
    lock_base = 5'd31;
    ent_wr = 1; fill_en = 1; ent_vtag = 14'h0101; ent_kind = 2'b11;
    ent_ptag = 22'h000777; ent_ap = 2'b01; ent_pres = 0;
    @(negedge clk); ent_wr = 0; fill_en = 0; lock_base = 0;
    look("R6 write wins", 24'h040400, 1, exp_pa(2'b11, 22'h000777, 24'h040400), 2'b01);
    set_ptr(31); ent_rd = 1;
    @(negedge clk); ent_rd = 0;
    chk("R6 no fill slot31", 64'(rd_valid), 0);
  endtask

  task automatic t_flush();
    do_reset();
    put(1, 14'h0400, 2'b00, 22'h100000, 2'b11, 0);  // va 1xxxxx, not kept
    put(2, 14'h0800, 2'b00, 22'h200000, 2'b11, 1);  // va 2xxxxx, kept
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
    look("R8 unkept gone", 24'h100010, 0, 0, 0);
    look("R8 kept stays", 24'h200010, 1, exp_pa(2'b00, 22'h200000, 24'h200010), 2'b11);
    @(negedge clk); flush_one = 1; flush_vtag = 14'h0800;
    @(negedge clk); flush_one = 0;
    look("R9 kept flushed by tag", 24'h200010, 0, 0, 0);
    // R11 flush and lookup in the same cycle
    put(4, 14'h0C00, 2'b00, 22'h300000, 2'b10, 0);
    @(negedge clk); flush_all = 1; req_valid = 1; req_vaddr = 24'h300020;
    @(negedge clk); flush_all = 0; req_valid = 0;
    chk("R11 flush first", 64'(rsp_hit), 0);
    put(5, 14'h1000, 2'b00, 22'h300000, 2'b10, 1);
    @(negedge clk); flush_one = 1; flush_vtag = 14'h1000; req_valid = 1; req_vaddr = 24'h400020;
    @(negedge clk); flush_one = 0; req_valid = 0;
    chk("R11 tag flush first", 64'(rsp_hit), 0);
  endtask

  task automatic t_lock();
    do_reset();
    for (int i = 0; i < 6; i++)
      put(i, 14'h0100 + 14'(i), 2'b11, 22'h001000 + 22'(i), 2'b01, 0);
    @(negedge clk); lock_base = 5'd6;
    for (int k = 0; k < 60; k++) begin
      fill_en = 1; ent_vtag = 14'h1000 + 14'(k); ent_kind = 2'b11;
      ent_ptag = 22'h300000 + 22'(k); ent_ap = 2'b11;
      @(negedge clk);
    end
    fill_en = 0;
    for (int i = 0; i < 6; i++) begin
      set_ptr(i); ent_rd = 1;
      @(negedge clk); ent_rd = 0;
      chk("R5 locked vtag", 64'(rd_vtag), 64'(14'h0100 + 14'(i)));
      chk("R5 locked valid", 64'(rd_valid), 1);
    end
    look("R5 last fill hits", {14'h1000 + 14'd59, 10'h2A}, 1,
         exp_pa(2'b11, 22'h300000 + 22'd59, {14'h1000 + 14'd59, 10'h2A}), 2'b11);
    set_ptr(31); ent_rd = 1;
    @(negedge clk); ent_rd = 0;
    chk("R10 fill keep flag clear", 64'(rd_pres), 0);
  endtask

  task automatic t_replace_kept();
    do_reset();
    put(31, 14'h0200, 2'b11, 22'h0ABCDE, 2'b11, 1);
    @(negedge clk); lock_base = 5'd31;
    fill_en = 1; ent_vtag = 14'h0300; ent_kind = 2'b11; ent_ptag = 22'h012345; ent_ap = 2'b10;
    @(negedge clk); fill_en = 0;
    look("R10 kept replaced", 24'h080000, 0, 0, 0);
    look("R10 new present", 24'h0C0011, 1, exp_pa(2'b11, 22'h012345, 24'h0C0011), 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    t_reset();
    t_sizes();
    t_handshake();
    t_readback();
    t_flush();
    t_lock();
    t_replace_kept();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule